// File: doc/BRIEF.md
# Dual-Bank Programmable Interrupt Controller

This block collects 32 asynchronous peripheral interrupt lines and presents them to a processor as two interrupt requests: a normal request and a fast request. It holds two register banks with the same layout. Each bank decides, per line, whether a line is enabled, whether it reacts to an edge or to a level, and which polarity counts as active. A register write/read port with word addressing lets software configure both banks, acknowledge latched edges and read back pending lines.

Every input first passes through a two-flop synchronizer. Edge-mode lines latch a pending bit when the chosen edge is seen, and the bit stays set until software acknowledges it. Level-mode lines are pending for as long as the input sits at its active level, and nothing is latched. Each bank ORs its enabled pending lines into a registered output.

Top module: `dual_bank_intc`

## Requirements
- R1: When reset is asserted, `irq_out` and `fiq_out` are 0. After reset, every readable register in both banks reads 0.
- R2: The word address selects the bank with bit 3 (0 = normal bank, 1 = fast bank) and the register with bits 2:0: 0 source, 1 enable, 2 acknowledge, 3 trigger mode, 4 polarity, 5 status. Word indices 6 and 7 of either bank read 0.
- R3: An enable bit of 1 lets its line reach the status and the output. A bit of 0 blocks it. With the enable register at 0, the bank's output is 0.
- R4: Writing 1 to an acknowledge bit clears that line's latched pending bit. Bits written 0 leave pending bits alone. Writing all ones clears every line. The acknowledge register reads 0.
- R5: The status register reads the pending lines ANDed with the enable register. A latched bit survives while its line is disabled and shows up once the line is enabled.
- R6: Trigger-mode bit 1 makes a line edge-triggered and latched. Bit 0 makes it level-sensitive: its pending bit follows the synchronized input, is never latched, and is not affected by the acknowledge register.
- R7: Polarity bit 1 means active-high or rising edge. Polarity bit 0 means active-low or falling edge.
- R8: If the active edge of a line is detected in the same cycle as an acknowledge write to that bit, the edge wins and the line stays pending.
- R9: Each output is registered and equals the OR of its bank's status. A level-mode input that changes just before clock edge 1 shows at the output after edge 3.
- R10: The source register returns the synchronized raw inputs, two clock edges after they change. Writes to the source and status offsets of either bank change nothing.
- R11: The two banks are independent. Configuration written to one bank has no effect on the other bank's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 32 | Asynchronous peripheral interrupt inputs |
| reg_wr_en | input | 1 | Register write strobe for the current cycle |
| reg_addr | input | 4 | Word address: bit 3 bank, bits 2:0 register |
| reg_wdata | input | 32 | Write data, one bit per line |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |

## Verification
The bench aims at the cycle where a detected edge meets an acknowledge write to the same bit. A design that lets the acknowledge win would lose an interrupt, and the status read would show the bit clear. It also latches an edge while the line is disabled and then enables the line, which exposes a design that gates the latch with the enable and so drops the request. It acknowledges a level-mode line while its input is active, pulses edges of both polarities, and writes all ones to the source and status offsets. A design that latched level lines, swapped polarity or decoded those offsets as writable would part from the reference model on the next output compare or read. The output latency is pinned to the exact cycle, so an extra or a missing register stage shows up at once.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register index inside one bank (word address bits 2:0).
  typedef enum logic [2:0] {
    IDX_SRC  = 3'd0,
    IDX_EN   = 3'd1,
    IDX_ACK  = 3'd2,
    IDX_MODE = 3'd3,
    IDX_POL  = 3'd4,
    IDX_STAT = 3'd5
  } reg_idx_e;

  localparam int unsigned IDX_W     = 3;
  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;

endmodule

// File: rtl/intc_in_sync.sv
module intc_in_sync #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_in,
  output logic [LINES-1:0] sync_cur,
  output logic [LINES-1:0] sync_prev
);

  logic [LINES-1:0] stg_q [STAGES];
  logic [LINES-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [LINES-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = async_in;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else begin
          stg_q[s] <= stg_d;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_cur  = stg_q[STAGES-1];
  assign sync_prev = prev_q;

endmodule

// File: rtl/intc_line_cell.sv
module intc_line_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic prev,
  input  logic edge_mode,
  input  logic act_high,
  input  logic ack,
  output logic edge_hit,
  output logic lat_q,
  output logic pend
);

  logic level_act;
  logic lat_d;

  always_comb begin
    if (act_high) begin
      edge_hit  = cur & ~prev;
      level_act = cur;
    end else begin
      edge_hit  = ~cur & prev;
      level_act = ~cur;
    end
    // A fresh edge overrides an acknowledge in the same cycle.
    lat_d = edge_mode & ((lat_q & ~ack) | edge_hit);
    pend  = edge_mode ? lat_q : level_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
    end
  end

endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] sync_cur,
  input  logic [LINES-1:0] sync_prev,
  output logic [LINES-1:0] rd_data,
  output logic             out_q,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] mode_q,
  output logic [LINES-1:0] pol_q,
  output logic [LINES-1:0] lat_q,
  output logic [LINES-1:0] ack_bits,
  output logic [LINES-1:0] edge_bits
);

  logic             en_we;
  logic             mode_we;
  logic             pol_we;
  logic [LINES-1:0] en_d;
  logic [LINES-1:0] mode_d;
  logic [LINES-1:0] pol_d;
  logic [LINES-1:0] pend;
  logic [LINES-1:0] status;
  logic             out_d;

  // Next-state logic
  always_comb begin
    en_we    = wr_en && (idx == IDX_EN);
    mode_we  = wr_en && (idx == IDX_MODE);
    pol_we   = wr_en && (idx == IDX_POL);
    ack_bits = (wr_en && (idx == IDX_ACK)) ? wdata : '0;
    en_d     = wdata;
    mode_d   = wdata;
    pol_d    = wdata;
    status   = pend & en_q;
    out_d    = |status;
  end

  // Registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else if (pol_we) begin
      pol_q <= pol_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else begin
      out_q <= out_d;
    end
  end

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      intc_line_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur       (sync_cur[i]),
        .prev      (sync_prev[i]),
        .edge_mode (mode_q[i]),
        .act_high  (pol_q[i]),
        .ack       (ack_bits[i]),
        .edge_hit  (edge_bits[i]),
        .lat_q     (lat_q[i]),
        .pend      (pend[i])
      );
    end
  endgenerate

  // Read view
  always_comb begin
    unique case (idx)
      IDX_SRC:  rd_data = sync_cur;
      IDX_EN:   rd_data = en_q;
      IDX_MODE: rd_data = mode_q;
      IDX_POL:  rd_data = pol_q;
      IDX_STAT: rd_data = status;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned LINES       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_lines,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic              irq_out,
  output logic              fiq_out
);

  localparam int unsigned BANK_BIT = IDX_W;

  logic             rst_q_n;
  logic [LINES-1:0] sync_cur;
  logic [LINES-1:0] sync_prev;
  logic             addr_in_range;
  logic             sel_bank;
  logic [IDX_W-1:0] sel_idx;

  logic [LINES-1:0] bank_rd   [NUM_BANKS];
  logic             bank_out  [NUM_BANKS];
  logic [LINES-1:0] bank_en   [NUM_BANKS];
  logic [LINES-1:0] bank_mode [NUM_BANKS];
  logic [LINES-1:0] bank_pol  [NUM_BANKS];
  logic [LINES-1:0] bank_lat  [NUM_BANKS];
  logic [LINES-1:0] bank_ack  [NUM_BANKS];
  logic [LINES-1:0] bank_edge [NUM_BANKS];

  intc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  intc_in_sync #(
    .LINES  (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .async_in  (irq_lines),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev)
  );

  always_comb begin
    addr_in_range = ((reg_addr >> (BANK_BIT + 1)) == '0);
    sel_bank      = reg_addr[BANK_BIT];
    sel_idx       = reg_addr[IDX_W-1:0];
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_we;
      assign bank_we = reg_wr_en && addr_in_range && (sel_bank == b[0]);
      intc_bank #(
        .LINES (LINES)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_q_n),
        .wr_en     (bank_we),
        .idx       (sel_idx),
        .wdata     (reg_wdata),
        .sync_cur  (sync_cur),
        .sync_prev (sync_prev),
        .rd_data   (bank_rd[b]),
        .out_q     (bank_out[b]),
        .en_q      (bank_en[b]),
        .mode_q    (bank_mode[b]),
        .pol_q     (bank_pol[b]),
        .lat_q     (bank_lat[b]),
        .ack_bits  (bank_ack[b]),
        .edge_bits (bank_edge[b])
      );
    end
  endgenerate

  always_comb begin
    if (addr_in_range) begin
      reg_rdata = sel_bank ? bank_rd[1] : bank_rd[0];
    end else begin
      reg_rdata = '0;
    end
  end

  assign irq_out = bank_out[0];
  assign fiq_out = bank_out[1];

  // Named views for the bound checker
  logic [LINES-1:0] n_en_q, f_en_q, n_mode_q, f_mode_q, n_pol_q;
  logic [LINES-1:0] n_lat_q, f_lat_q, n_ack, f_ack, n_edge, f_edge, f_pol_q;
  assign n_en_q   = bank_en[0];
  assign f_en_q   = bank_en[1];
  assign n_mode_q = bank_mode[0];
  assign f_mode_q = bank_mode[1];
  assign n_pol_q  = bank_pol[0];
  assign f_pol_q  = bank_pol[1];
  assign n_lat_q  = bank_lat[0];
  assign f_lat_q  = bank_lat[1];
  assign n_ack    = bank_ack[0];
  assign f_ack    = bank_ack[1];
  assign n_edge   = bank_edge[0];
  assign f_edge   = bank_edge[1];

endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_raw_n,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [LINES-1:0]  n_en,
  input logic [LINES-1:0]  f_en,
  input logic [LINES-1:0]  n_mode,
  input logic [LINES-1:0]  f_mode,
  input logic [LINES-1:0]  n_pol,
  input logic [LINES-1:0]  f_pol,
  input logic [LINES-1:0]  n_lat,
  input logic [LINES-1:0]  f_lat,
  input logic [LINES-1:0]  n_ack,
  input logic [LINES-1:0]  f_ack,
  input logic [LINES-1:0]  n_edge,
  input logic [LINES-1:0]  f_edge
);

  // R1: outputs are quiet while the external reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_raw_n |-> (!irq_out && !fiq_out));

  // R3: a fully disabled bank cannot raise its output on the next cycle
  a_r3_irq_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (n_en == '0) |=> !irq_out);

  a_r3_fiq_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (f_en == '0) |=> !fiq_out);

  // R6: a latched edge-mode bit persists unless it is acknowledged
  a_r6_irq_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_lat & ~n_ack & n_mode) != '0) |=>
      ((n_lat & $past(n_lat & ~n_ack & n_mode)) == $past(n_lat & ~n_ack & n_mode)));

  a_r6_fiq_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_lat & ~f_ack & f_mode) != '0) |=>
      ((f_lat & $past(f_lat & ~f_ack & f_mode)) == $past(f_lat & ~f_ack & f_mode)));

  // R8: an edge coinciding with its acknowledge leaves the line pending
  a_r8_irq_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((n_edge & n_ack & n_mode) != '0) |=>
      ((n_lat & $past(n_edge & n_ack & n_mode)) == $past(n_edge & n_ack & n_mode)));

  a_r8_fiq_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((f_edge & f_ack & f_mode) != '0) |=>
      ((f_lat & $past(f_edge & f_ack & f_mode)) == $past(f_edge & f_ack & f_mode)));

  // R10: writes to the source or status offsets leave configuration alone
  a_r10_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr[2:0] == 3'd0 || addr[2:0] == 3'd5)) |=>
      ($stable(n_en) && $stable(f_en) && $stable(n_mode) && $stable(f_mode) &&
       $stable(n_pol) && $stable(f_pol)));

endmodule

bind dual_bank_intc intc_checker #(
  .LINES  (LINES),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_raw_n (rst_n),
  .rst_n     (rst_q_n),
  .wr_en     (reg_wr_en),
  .addr      (reg_addr),
  .irq_out   (irq_out),
  .fiq_out   (fiq_out),
  .n_en      (n_en_q),
  .f_en      (f_en_q),
  .n_mode    (n_mode_q),
  .f_mode    (f_mode_q),
  .n_pol     (n_pol_q),
  .f_pol     (f_pol_q),
  .n_lat     (n_lat_q),
  .f_lat     (f_lat_q),
  .n_ack     (n_ack),
  .f_ack     (f_ack),
  .n_edge    (n_edge),
  .f_edge    (f_edge)
);

// File: tb/dual_bank_intc_tb_top.sv
module dual_bank_intc_tb_top;

  localparam int A_SRC = 0, A_EN = 1, A_ACK = 2, A_MODE = 3, A_POL = 4, A_STAT = 5;
  localparam int F = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [31:0] irq_lines = '0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  logic        fiq_out;

  int total = 0, bad = 0, cyc_total = 0, cyc_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_bank_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  // Behavioural reference model
  logic [31:0] m_s1 = '0, m_s2 = '0, m_pv = '0;
  logic        m_rs1 = 0, m_rs2 = 0;
  logic [31:0] m_en [2];
  logic [31:0] m_mode [2];
  logic [31:0] m_pol [2];
  logic [31:0] m_lat [2];
  logic        m_out [2];

  function automatic logic [31:0] m_pend(int b);
    logic [31:0] lvl;
    lvl = (m_pol[b] & m_s2) | (~m_pol[b] & ~m_s2);
    return (m_mode[b] & m_lat[b]) | (~m_mode[b] & lvl);
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    int b;
    b = a[3] ? 1 : 0;
    case (a[2:0])
      3'd0: return m_s2;
      3'd1: return m_en[b];
      3'd3: return m_mode[b];
      3'd4: return m_pol[b];
      3'd5: return m_pend(b) & m_en[b];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] n_lat [2];
    logic        n_out [2];
    logic [31:0] ack, edg;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_rs1 = 0; m_rs2 = 0;
      for (int b = 0; b < 2; b++) begin
        m_en[b] = '0; m_mode[b] = '0; m_pol[b] = '0; m_lat[b] = '0; m_out[b] = 0;
      end
    end else begin
      if (m_rs2) begin
        for (int b = 0; b < 2; b++) begin
          ack = (reg_wr_en && reg_addr[3] == b[0] && reg_addr[2:0] == 3'd2) ? reg_wdata : '0;
          edg = (m_pol[b] & m_s2 & ~m_pv) | (~m_pol[b] & ~m_s2 & m_pv);
          n_lat[b] = m_mode[b] & ((m_lat[b] & ~ack) | edg);
          n_out[b] = |(m_pend(b) & m_en[b]);
        end
        for (int b = 0; b < 2; b++) begin
          m_lat[b] = n_lat[b];
          m_out[b] = n_out[b];
          if (reg_wr_en && reg_addr[3] == b[0]) begin
            if (reg_addr[2:0] == 3'd1) m_en[b] = reg_wdata;
            if (reg_addr[2:0] == 3'd3) m_mode[b] = reg_wdata;
            if (reg_addr[2:0] == 3'd4) m_pol[b] = reg_wdata;
          end
        end
        m_pv = m_s2; m_s2 = m_s1; m_s1 = irq_lines;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  // R9: outputs compared with the model on every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc_total++;
      if (irq_out !== m_out[0] || fiq_out !== m_out[1]) begin
        cyc_bad++;
        $display("FAIL R9 cycle compare: irq/fiq actual=%b%b expected=%b%b",
                 irq_out, fiq_out, m_out[0], m_out[1]);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd(int a, string req);
    reg_addr = 4'(a);
    #1;
    chk(req, reg_rdata, m_read(4'(a)));
    reg_addr = '0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total + cyc_total, bad + cyc_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    tick(2);
    chk("R1 irq in reset", {31'd0, irq_out}, 32'd0);
    chk("R1 fiq in reset", {31'd0, fiq_out}, 32'd0);
    tick(2);
    rst_n = 1'b1;
    tick(4);

    // R1 / R2: every word reads its reset value
    for (int a = 0; a < 16; a++) rd(a, "R1 R2 reset read");
    reg_addr = 4'(A_EN); #1; chk("R1 enable zero", reg_rdata, 32'd0);

    // R10: source view and read-only offsets
    irq_lines = 32'h0000_00A5;
    tick(3);
    reg_addr = 4'(A_SRC); #1; chk("R10 source view", reg_rdata, 32'h0000_00A5);
    reg_addr = 4'(F + A_SRC); #1; chk("R10 source view fast", reg_rdata, 32'h0000_00A5);
    wr(A_SRC, 32'hFFFF_FFFF); wr(A_STAT, 32'hFFFF_FFFF);
    wr(F + A_SRC, 32'hFFFF_FFFF); wr(F + A_STAT, 32'hFFFF_FFFF);
    tick(1);
    for (int a = 0; a < 16; a++) rd(a, "R10 ro writes ignored");
    reg_addr = 4'(F + A_EN); #1; chk("R10 fast enable still zero", reg_rdata, 32'd0);
    irq_lines = '0;
    tick(4);

    // R6 / R7: level active-high on line 0, normal bank
    wr(A_POL, 32'h1); wr(A_EN, 32'h1);
    irq_lines[0] = 1'b1; tick(5);
    chk("R6 level asserted", {31'd0, irq_out}, 32'd1);
    rd(A_STAT, "R5 status level");
    irq_lines[0] = 1'b0; tick(5);
    chk("R6 level not latched", {31'd0, irq_out}, 32'd0);

    // R7 / R11: active-low line 3 on fast bank only
    wr(F + A_EN, 32'h8); tick(4);
    chk("R7 active low", {31'd0, fiq_out}, 32'd1);
    chk("R11 normal bank untouched", {31'd0, irq_out}, 32'd0);
    irq_lines[3] = 1'b1; tick(5);
    chk("R7 active low released", {31'd0, fiq_out}, 32'd0);

    // R6 / R4: rising edge latch on line 5
    wr(A_MODE, 32'h20); wr(A_POL, 32'h21); wr(A_EN, 32'h21);
    irq_lines[5] = 1'b1; tick(3); irq_lines[5] = 1'b0; tick(5);
    chk("R6 edge latched", {31'd0, irq_out}, 32'd1);
    rd(A_STAT, "R5 status edge");
    wr(A_ACK, 32'h0000_0010); tick(3);
    chk("R4 ack of other bit keeps", {31'd0, irq_out}, 32'd1);
    wr(A_ACK, 32'h20); tick(3);
    chk("R4 ack clears", {31'd0, irq_out}, 32'd0);
    rd(A_ACK, "R4 ack reads zero");

    // R7: falling edge on line 7, fast bank
    wr(F + A_MODE, 32'h80); wr(F + A_EN, 32'h88);
    irq_lines[7] = 1'b1; tick(5);
    chk("R7 rising ignored by falling line", {31'd0, fiq_out}, 32'd0);
    irq_lines[7] = 1'b0; tick(5);
    chk("R7 falling edge latched", {31'd0, fiq_out}, 32'd1);

    // R4: all-ones acknowledge on both banks
    irq_lines[5] = 1'b1; tick(3); irq_lines[5] = 1'b0; tick(4);
    wr(A_ACK, 32'hFFFF_FFFF); wr(F + A_ACK, 32'hFFFF_FFFF); tick(3);
    chk("R4 all ones normal", {31'd0, irq_out}, 32'd0);
    chk("R4 all ones fast", {31'd0, fiq_out}, 32'd0);

    // R3 / R5: latch while disabled, then enable
    wr(A_EN, 32'h0);
    irq_lines[5] = 1'b1; tick(3); irq_lines[5] = 1'b0; tick(4);
    chk("R3 disabled quiet", {31'd0, irq_out}, 32'd0);
    reg_addr = 4'(A_STAT); #1; chk("R5 status masked", reg_rdata, 32'd0); reg_addr = '0;
    wr(A_EN, 32'h20); tick(3);
    chk("R5 held pending shows", {31'd0, irq_out}, 32'd1);
    wr(A_ACK, 32'h20); tick(3);

    // R8: edge and acknowledge in the same cycle on line 9
    wr(A_MODE, 32'h220); wr(A_POL, 32'h221); wr(A_EN, 32'h220);
    irq_lines[9] = 1'b1;
    tick(2);
    wr(A_ACK, 32'h200);
    tick(2);
    reg_addr = 4'(A_STAT); #1; chk("R8 edge wins over ack", reg_rdata & 32'h200, 32'h200);
    reg_addr = '0;
    tick(1);
    chk("R8 output held", {31'd0, irq_out}, 32'd1);

    // R6: acknowledge has no effect on an active level line
    wr(A_ACK, 32'hFFFF_FFFF); wr(A_EN, 32'h1);
    irq_lines[0] = 1'b1; tick(5);
    wr(A_ACK, 32'h1); tick(3);
    reg_addr = 4'(A_STAT); #1; chk("R6 ack ignored on level line", reg_rdata, 32'h1);
    reg_addr = '0;
    chk("R6 level output stays", {31'd0, irq_out}, 32'd1);

    // R9: exact latency of a level input to the output
    irq_lines[0] = 1'b0; tick(5);
    chk("R9 idle before step", {31'd0, irq_out}, 32'd0);
    irq_lines[0] = 1'b1;
    tick(2);
    chk("R9 not yet after two edges", {31'd0, irq_out}, 32'd0);
    tick(1);
    chk("R9 asserted after three edges", {31'd0, irq_out}, 32'd1);

    for (int a = 0; a < 16; a++) rd(a, "R2 final readback");
    tick(2);
    done = 1;
    summary();
    $finish;
  end

endmodule